// File: doc/BRIEF.md
# ADC Threshold Alarm with Trip Counting

This block watches a stream of 12-bit conversion results and raises an alarm when results drift past programmed limits. There are two channels. The upper channel trips on results strictly above its limit, and the lower channel trips on results strictly below its limit. Each channel has a required trip count of 1 to 8. Each channel also has a run mode, which selects whether trips are counted cumulatively or only as an unbroken run. When a channel reaches its count, it sets a sticky flag, and that flag stays set until it is cleared explicitly.

Results arrive on a valid/ready stream. `res_ready` is low during reset and stays high from the first clock after reset. A result is consumed on every cycle where both `res_valid` and `res_ready` are high, so the block never applies back-pressure. Each channel is configured through its own one-cycle write strobe, which loads the limit, the count field and the run mode. The two flags can be cleared independently. The flags are masked and combined into a single interrupt line.

Top module: `adc_thresh_alarm`

## Requirements
- R1: After reset both flags and `irq` are 0. The upper limit resets to 0xFFF and the lower limit to 0x000, both with count field 0 and cumulative mode. As a result, a 0xFFF result and a 0x000 result raise no flag.
- R2: The upper channel counts a result as a trip only when the result is strictly greater than its limit. A result equal to the limit is not a trip.
- R3: The lower channel counts a result as a trip only when the result is strictly less than its limit. A result equal to the limit is not a trip.
- R4: The 3-bit count field value `k` requires `k+1` trips (1 to 8). The flag rises on the clock edge that accepts the trip reaching that count.
- R5: With the run-mode bit at 0 (cumulative), a non-tripping result leaves the channel's count unchanged.
- R6: With the run-mode bit at 1 (consecutive), a non-tripping result returns the channel's count to zero.
- R7: A write to a channel's configuration returns that channel's count to zero. A result accepted in the same cycle as that write is not counted by that channel.
- R8: A flag stays set until a clear, given by `sts_clr` bit 0 for the upper channel and bit 1 for the lower channel. If a clear and a completing trip arrive in the same cycle, the flag stays set.
- R9: The count saturates at the required value. After a clear, a single further trip sets the flag again without a configuration write.
- R10: `irq` is high when any flag is set whose mask bit is 0. Mask bit 0 gates the upper flag and mask bit 1 gates the lower flag, and a mask bit of 1 blocks its flag.
- R11: `res_ready` is high from the first cycle after reset. Data presented while `res_valid` is low has no effect on either channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready |
| res_data | input | 12 | Conversion result |
| gt_wr | input | 1 | Upper channel configuration write strobe |
| gt_wr_limit | input | 12 | Upper limit written on `gt_wr` |
| gt_wr_trips | input | 3 | Upper count field (trips minus one) |
| gt_wr_consec | input | 1 | Upper run mode (1 = consecutive) |
| lt_wr | input | 1 | Lower channel configuration write strobe |
| lt_wr_limit | input | 12 | Lower limit written on `lt_wr` |
| lt_wr_trips | input | 3 | Lower count field (trips minus one) |
| lt_wr_consec | input | 1 | Lower run mode (1 = consecutive) |
| sts_clr | input | 2 | Flag clear strobes (bit 0 upper, bit 1 lower) |
| irq_mask | input | 2 | Interrupt mask (bit 0 upper, bit 1 lower) |
| gt_flag | output | 1 | Sticky upper-alarm flag |
| lt_flag | output | 1 | Sticky lower-alarm flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default parameters, a 12-bit data width and a 3-bit count field. The 12-bit width places the full-scale value 0xFFF within reach, which exposes the reset limit at the edge of the range. The 3-bit field allows the eight-trip ceiling to be reached in a few dozen cycles. Directed scenarios exercise the following:
- equality at both limits;
- interleaved non-trips in both run modes;
- a configuration write landing on the same cycle as a result;
- a clear colliding with a completing trip.

// File: rtl/adc_alarm_pkg.sv
package adc_alarm_pkg;
  typedef enum logic {
    CMP_ABOVE = 1'b0,
    CMP_BELOW = 1'b1
  } cmp_dir_e;

  localparam int unsigned NUM_CHAN = 2;
  localparam int unsigned CH_UPPER = 0;
  localparam int unsigned CH_LOWER = 1;
endpackage

// File: rtl/adc_alarm_cmp.sv
module adc_alarm_cmp
  import adc_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter cmp_dir_e    DIR    = CMP_ABOVE
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] limit,
  output logic              trip
);
  generate
    if (DIR == CMP_ABOVE) begin : g_above
      assign trip = (sample > limit);
    end else begin : g_below
      assign trip = (sample < limit);
    end
  endgenerate
endmodule

// File: rtl/adc_alarm_chan.sv
module adc_alarm_chan
  import adc_alarm_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned TRIP_W  = 3,
  parameter cmp_dir_e    DIR     = CMP_ABOVE,
  parameter logic [DATA_W-1:0] RST_LIMIT = '0,
  localparam int unsigned CNT_W = TRIP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_limit,
  input  logic [TRIP_W-1:0] cfg_trips,
  input  logic              cfg_consec,
  input  logic              res_fire,
  input  logic [DATA_W-1:0] res_data,
  input  logic              flag_clr,
  output logic              flag,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  target
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [DATA_W-1:0] limit_q;
  logic [TRIP_W-1:0] trips_q;
  logic              consec_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              flag_q;
  logic              trip;
  logic              reach;

  adc_alarm_cmp #(.DATA_W(DATA_W), .DIR(DIR)) cmp_i (
    .sample (res_data),
    .limit  (limit_q),
    .trip   (trip)
  );

  assign target = {1'b0, trips_q} + ONE;

  always_comb begin
    cnt_d = cnt_q;
    reach = 1'b0;
    if (cfg_wr) begin
      cnt_d = '0;
    end else if (res_fire) begin
      if (trip) begin
        if (cnt_q < target) cnt_d = cnt_q + ONE;
        reach = ((cnt_q + ONE) >= target);
      end else if (consec_q) begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q  <= RST_LIMIT;
      trips_q  <= '0;
      consec_q <= 1'b0;
      cnt_q    <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        limit_q  <= cfg_limit;
        trips_q  <= cfg_trips;
        consec_q <= cfg_consec;
      end
      cnt_q <= cnt_d;
      if (reach)         flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/adc_thresh_alarm.sv
module adc_thresh_alarm
  import adc_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned TRIP_W = 3,
  localparam int unsigned CNT_W = TRIP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic              gt_wr,
  input  logic [DATA_W-1:0] gt_wr_limit,
  input  logic [TRIP_W-1:0] gt_wr_trips,
  input  logic              gt_wr_consec,
  input  logic              lt_wr,
  input  logic [DATA_W-1:0] lt_wr_limit,
  input  logic [TRIP_W-1:0] lt_wr_trips,
  input  logic              lt_wr_consec,
  input  logic [1:0]        sts_clr,
  input  logic [1:0]        irq_mask,
  output logic              gt_flag,
  output logic              lt_flag,
  output logic              irq
);
  logic                              ready_q;
  logic                              res_fire;
  logic [NUM_CHAN-1:0]               wr_vec;
  logic [NUM_CHAN-1:0][DATA_W-1:0]   limit_vec;
  logic [NUM_CHAN-1:0][TRIP_W-1:0]   trips_vec;
  logic [NUM_CHAN-1:0]               consec_vec;
  logic [NUM_CHAN-1:0]               flag_vec;
  logic [NUM_CHAN-1:0][CNT_W-1:0]    chan_cnt;
  logic [NUM_CHAN-1:0][CNT_W-1:0]    chan_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign res_ready = ready_q;
  assign res_fire  = res_valid & ready_q;

  assign wr_vec     = {lt_wr, gt_wr};
  assign limit_vec  = {lt_wr_limit, gt_wr_limit};
  assign trips_vec  = {lt_wr_trips, gt_wr_trips};
  assign consec_vec = {lt_wr_consec, gt_wr_consec};

  generate
    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
      localparam cmp_dir_e CH_DIR = (g == CH_UPPER) ? CMP_ABOVE : CMP_BELOW;
      localparam logic [DATA_W-1:0] CH_RST = (g == CH_UPPER) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
      adc_alarm_chan #(
        .DATA_W    (DATA_W),
        .TRIP_W    (TRIP_W),
        .DIR       (CH_DIR),
        .RST_LIMIT (CH_RST)
      ) chan_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (wr_vec[g]),
        .cfg_limit  (limit_vec[g]),
        .cfg_trips  (trips_vec[g]),
        .cfg_consec (consec_vec[g]),
        .res_fire   (res_fire),
        .res_data   (res_data),
        .flag_clr   (sts_clr[g]),
        .flag       (flag_vec[g]),
        .cnt        (chan_cnt[g]),
        .target     (chan_tgt[g])
      );
    end
  endgenerate

  assign gt_flag = flag_vec[CH_UPPER];
  assign lt_flag = flag_vec[CH_LOWER];
  assign irq     = |(flag_vec & ~irq_mask);
endmodule

// File: rtl/adc_thresh_alarm_chk.sv
module adc_thresh_alarm_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  res_valid,
  input logic                  res_ready,
  input logic                  gt_wr,
  input logic                  lt_wr,
  input logic [1:0]            sts_clr,
  input logic [1:0]            irq_mask,
  input logic                  gt_flag,
  input logic                  lt_flag,
  input logic                  irq,
  input logic [1:0][CNT_W-1:0] cnt_vec,
  input logic [1:0][CNT_W-1:0] tgt_vec
);
  // R7
  gt_wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gt_wr |=> (cnt_vec[0] == '0));
  // R7
  lt_wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_wr |=> (cnt_vec[1] == '0));
  // R9
  gt_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_vec[0] <= tgt_vec[0]);
  // R9
  lt_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_vec[1] <= tgt_vec[1]);
  // R8
  gt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gt_flag && !sts_clr[0]) |=> gt_flag);
  // R8
  lt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_flag && !sts_clr[1]) |=> lt_flag);
  // R8
  gt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr[0] && !res_valid) |=> !gt_flag);
  // R11
  gt_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gt_flag) |-> $past(res_valid && res_ready));
  // R11
  lt_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lt_flag) |-> $past(res_valid && res_ready));
  // R10
  irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gt_flag && !irq_mask[0]) || (lt_flag && !irq_mask[1])) |-> irq);
  // R10
  irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 2'b11) |-> !irq);
  // R11
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |=> res_ready);
endmodule

bind adc_thresh_alarm adc_thresh_alarm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .gt_wr     (gt_wr),
  .lt_wr     (lt_wr),
  .sts_clr   (sts_clr),
  .irq_mask  (irq_mask),
  .gt_flag   (gt_flag),
  .lt_flag   (lt_flag),
  .irq       (irq),
  .cnt_vec   (chan_cnt),
  .tgt_vec   (chan_tgt)
);

// File: tb/adc_thresh_alarm_tb_top.sv
`timescale 1ns/1ps
module adc_thresh_alarm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [11:0] res_data = '0;
  logic        gt_wr = 1'b0;
  logic [11:0] gt_wr_limit = '0;
  logic [2:0]  gt_wr_trips = '0;
  logic        gt_wr_consec = 1'b0;
  logic        lt_wr = 1'b0;
  logic [11:0] lt_wr_limit = '0;
  logic [2:0]  lt_wr_trips = '0;
  logic        lt_wr_consec = 1'b0;
  logic [1:0]  sts_clr = '0;
  logic [1:0]  irq_mask = 2'b11;
  logic        gt_flag, lt_flag, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_thresh_alarm dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .gt_wr(gt_wr), .gt_wr_limit(gt_wr_limit),
    .gt_wr_trips(gt_wr_trips), .gt_wr_consec(gt_wr_consec), .lt_wr(lt_wr),
    .lt_wr_limit(lt_wr_limit), .lt_wr_trips(lt_wr_trips),
    .lt_wr_consec(lt_wr_consec), .sts_clr(sts_clr), .irq_mask(irq_mask),
    .gt_flag(gt_flag), .lt_flag(lt_flag), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] d);
    @(negedge clk);
    res_valid = 1'b1; res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic cfg_gt(input logic [11:0] lim, input logic [2:0] tr, input logic cm);
    @(negedge clk);
    gt_wr = 1'b1; gt_wr_limit = lim; gt_wr_trips = tr; gt_wr_consec = cm;
    @(negedge clk);
    gt_wr = 1'b0;
  endtask

  task automatic cfg_lt(input logic [11:0] lim, input logic [2:0] tr, input logic cm);
    @(negedge clk);
    lt_wr = 1'b1; lt_wr_limit = lim; lt_wr_trips = tr; lt_wr_consec = cm;
    @(negedge clk);
    lt_wr = 1'b0;
  endtask

  task automatic clear(input logic [1:0] which);
    @(negedge clk);
    sts_clr = which;
    @(negedge clk);
    sts_clr = '0;
  endtask

  task automatic t_reset();
    check("R1 gt_flag after reset", gt_flag, 0);
    check("R1 lt_flag after reset", lt_flag, 0);
    check("R1 irq after reset", irq, 0);
    check("R11 ready after reset", res_ready, 1);
    irq_mask = 2'b00;
    send(12'hFFF);
    check("R1 default upper limit 0xFFF", gt_flag, 0);
    send(12'h000);
    check("R1 default lower limit 0x000", lt_flag, 0);
    check("R1 irq still low", irq, 0);
  endtask

  task automatic t_upper_strict();
    cfg_gt(12'h800, 3'd0, 1'b0);
    send(12'h800);
    check("R2 equal is no trip", gt_flag, 0);
    send(12'h801);
    check("R2 above trips, R4 count 1", gt_flag, 1);
    irq_mask = 2'b00;
    #1 check("R10 unmasked irq", irq, 1);
    irq_mask = 2'b01;
    #1 check("R10 masked irq", irq, 0);
    clear(2'b01);
    check("R8 clear upper", gt_flag, 0);
    send(12'h801);
    check("R9 saturated count re-raises", gt_flag, 1);
    clear(2'b01);
  endtask

  task automatic t_lower_cumulative();
    cfg_lt(12'h100, 3'd2, 1'b0);
    send(12'h100);
    check("R3 equal is no trip", lt_flag, 0);
    send(12'h0FF);
    send(12'h200);
    send(12'h0FF);
    check("R5 two trips not enough", lt_flag, 0);
    send(12'h0FF);
    check("R5 third trip across gaps", lt_flag, 1);
    irq_mask = 2'b01;
    #1 check("R10 lower irq bit 1", irq, 1);
    irq_mask = 2'b11;
    clear(2'b10);
    check("R8 clear lower", lt_flag, 0);
  endtask

  task automatic t_consecutive();
    cfg_gt(12'h400, 3'd2, 1'b1);
    send(12'h500); send(12'h500); send(12'h300);
    send(12'h500); send(12'h500);
    check("R6 broken run does not fire", gt_flag, 0);
    send(12'h500);
    check("R6 three in a row fires", gt_flag, 1);
    clear(2'b01);
  endtask

  task automatic t_rewrite();
    cfg_gt(12'h400, 3'd1, 1'b0);
    send(12'h500);
    cfg_gt(12'h400, 3'd1, 1'b0);
    send(12'h500);
    check("R7 write restarts count", gt_flag, 0);
    @(negedge clk);
    gt_wr = 1'b1; res_valid = 1'b1; res_data = 12'h500;
    @(negedge clk);
    gt_wr = 1'b0; res_valid = 1'b0;
    send(12'h500);
    check("R7 same-cycle result ignored", gt_flag, 0);
    send(12'h500);
    check("R7 counts after write", gt_flag, 1);
  endtask

  task automatic t_set_wins();
    cfg_gt(12'h400, 3'd0, 1'b0);
    @(negedge clk);
    sts_clr = 2'b01; res_valid = 1'b1; res_data = 12'h500;
    @(negedge clk);
    sts_clr = '0; res_valid = 1'b0;
    check("R8 set wins over clear", gt_flag, 1);
    clear(2'b01);
  endtask

  task automatic t_valid_low();
    cfg_gt(12'h010, 3'd0, 1'b0);
    @(negedge clk);
    res_data = 12'hFFF;
    repeat (4) @(negedge clk);
    check("R11 no effect without valid", gt_flag, 0);
  endtask

  task automatic t_max_count();
    cfg_lt(12'h800, 3'd7, 1'b0);
    for (int i = 0; i < 7; i++) send(12'h001);
    check("R4 seven of eight trips", lt_flag, 0);
    send(12'h001);
    check("R4 eighth trip fires", lt_flag, 1);
    clear(2'b10);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_upper_strict();
    t_lower_cumulative();
    t_consecutive();
    t_rewrite();
    t_set_wins();
    t_valid_low();
    t_max_count();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule